// File: doc/BRIEF.md
# Programmable Option Select Register Responder

This block is the adapter-side responder for the Micro Channel Programmable Option Select space. It watches the bus strobes, the read/write qualifier, the 16-bit I/O address and this slot's card-setup select. It decides whether a cycle is a setup access aimed at this slot. On a read it returns one of eight option-select bytes, and on a write it takes the value into a small register file. A host identifies the adapter by reading its fixed ID bytes and then programs the option bytes to enable it.

Some hosts raise the setup select before the address strobe and drop it partway through the command phase. For that reason the select, the read/write qualifier, the address, terminal count and DMA grant are all frozen in one snapshot on the falling edge of the address strobe. Every later decision uses that snapshot and never the live pins. All inputs are assumed to be already synchronous to `clk`. The data bus is presented as a value plus an output enable, to be wired to a pad driver.

Top module: `mca_pos_responder`

## Requirements
- R1: A cycle is a setup access when the captured address lies in 0x0100..0x0107, with all 16 bits compared. Address bits [2:0] select the byte index 0..7. Any other address never raises `data_oe`.
- R2: `setup_sel` HIGH means asserted. When the captured select is low, the block neither drives nor stores anything: `data_oe` stays 0, `data_out` reads 0x00 and the registers keep their values.
- R3: Address, `io_read`, `setup_sel`, `tc_in` and `grant_in` are captured at the first clock edge on which `adl_n` is seen low after being high. Later changes on these pins have no effect until the next such edge, so a select that drops during the command phase still gets an answer, and a select that rises only after the strobe gets none.
- R4: Reads of byte 0 return the low byte of ADAPTER_ID (default 0x7E91, so 0x91), and reads of byte 1 return the high byte (0x7E). Bytes 6 and 7 read 0x00.
- R5: Bytes 2..5 are read/write and reset to 0x00. A write stores `data_in` as sampled on the clock edge at which `cmd_n` is first seen high after being low.
- R6: Writes to bytes 0, 1, 6 and 7 are ignored, and the bytes keep their read values.
- R7: `data_oe` is 1 exactly while `cmd_n` is low, the captured select is asserted, the captured address hits, and the captured `io_read` is 1 (1 = read, 0 = write). `data_out` is 0x00 whenever `data_oe` is 0.
- R8: `card_enable` equals bit 0 of byte 2.
- R9: `snap_tc` and `snap_grant` present the terminal-count and grant levels captured with the address, and they hold until the next address strobe.
- R10: Synchronous active-high `rst` clears bytes 2..5 and the snapshot. After reset, `data_oe` stays 0 until a new address strobe is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| adl_n | input | 1 | Address strobe, active low |
| cmd_n | input | 1 | Command strobe, active low |
| io_read | input | 1 | Cycle direction, 1 = read, 0 = write |
| addr | input | 16 | I/O address |
| setup_sel | input | 1 | Slot card-setup select after the inverting buffer, high = asserted |
| tc_in | input | 1 | Terminal-count qualifier |
| grant_in | input | 1 | DMA-grant qualifier |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data toward the bus driver |
| data_oe | output | 1 | Enable for the bus driver |
| card_enable | output | 1 | Adapter enable, byte 2 bit 0 |
| snap_tc | output | 1 | Captured terminal count |
| snap_grant | output | 1 | Captured DMA grant |

## Verification
Reads and writes are walked across all eight byte indices. This separates the fixed ID bytes, the read/write bytes and the hardwired-zero bytes, and it shows which writes land and which are dropped. Addresses one past the window and with upper bits set show that the whole address is decoded. The select is varied in three patterns: held through the cycle, dropped right after the address strobe, and raised only in the command phase. The first two must be answered and the third must not, which shows that the snapshot decides and the live pin does not. Terminal count and grant are pulsed only around the strobe to show they are captured. A reset in the middle of a session shows the options and the snapshot being cleared.

// File: rtl/mca_pos_pkg.sv
package mca_pos_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              setup;
    logic              tc;
    logic              grant;
  } pos_snap_t;

  // Address falls inside the eight-byte window starting at base
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
    return a[ADDR_W-1:IDX_W] == base[ADDR_W-1:IDX_W];
  endfunction

  // Option bytes 2..5 accept writes
  function automatic logic idx_writable(input logic [IDX_W-1:0] idx);
    return (idx >= 3'd2) && (idx <= 3'd5);
  endfunction

  // Option-register slot for a writable index
  function automatic int unsigned opt_slot(input logic [IDX_W-1:0] idx);
    return int'(idx) - 2;
  endfunction

endpackage

// File: rtl/mca_pos_snapshot.sv
module mca_pos_snapshot
  import mca_pos_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adl_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_read,
  input  logic              setup_sel,
  input  logic              tc_in,
  input  logic              grant_in,
  output logic              adl_fall,
  output pos_snap_t         snap
);

  logic adl_q;

  assign adl_fall = adl_q && !adl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      adl_q <= 1'b1;
      snap  <= '0;
    end else begin
      adl_q <= adl_n;
      if (adl_fall) begin
        snap.addr  <= addr;
        snap.rd    <= io_read;
        snap.setup <= setup_sel;
        snap.tc    <= tc_in;
        snap.grant <= grant_in;
      end
    end
  end

endmodule

// File: rtl/mca_pos_regfile.sv
module mca_pos_regfile
  import mca_pos_pkg::*;
#(
  parameter logic [15:0] ADAPTER_ID = 16'h7E91,
  parameter int          N_OPT      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic              opt_bit0
);

  logic [BYTE_W-1:0] opt_q [N_OPT];

  for (genvar g = 0; g < N_OPT; g++) begin : g_opt
    always_ff @(posedge clk) begin
      if (rst) begin
        opt_q[g] <= '0;
      end else if (wr_stb && idx_writable(wr_idx) && opt_slot(wr_idx) == g) begin
        opt_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    unique case (rd_idx)
      3'd0:    rd_data = ADAPTER_ID[7:0];
      3'd1:    rd_data = ADAPTER_ID[15:8];
      3'd2:    rd_data = opt_q[0];
      3'd3:    rd_data = opt_q[1];
      3'd4:    rd_data = opt_q[2];
      3'd5:    rd_data = opt_q[3];
      default: rd_data = '0;
    endcase
  end

  assign opt_bit0 = opt_q[0][0];

endmodule

// File: rtl/mca_pos_responder.sv
module mca_pos_responder
  import mca_pos_pkg::*;
#(
  parameter logic [15:0] POS_BASE   = 16'h0100,
  parameter logic [15:0] ADAPTER_ID = 16'h7E91
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adl_n,
  input  logic        cmd_n,
  input  logic        io_read,
  input  logic [15:0] addr,
  input  logic        setup_sel,
  input  logic        tc_in,
  input  logic        grant_in,
  input  logic [7:0]  data_in,
  output logic [7:0]  data_out,
  output logic        data_oe,
  output logic        card_enable,
  output logic        snap_tc,
  output logic        snap_grant
);

  pos_snap_t         snap;
  logic              adl_fall;
  logic              cmd_q;
  logic              cmd_rise;
  logic              snap_hit;
  logic              wr_stb;
  logic [IDX_W-1:0]  pos_idx;
  logic [BYTE_W-1:0] rd_data;

  mca_pos_snapshot u_snap (
    .clk       (clk),
    .rst       (rst),
    .adl_n     (adl_n),
    .addr      (addr),
    .io_read   (io_read),
    .setup_sel (setup_sel),
    .tc_in     (tc_in),
    .grant_in  (grant_in),
    .adl_fall  (adl_fall),
    .snap      (snap)
  );

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= 1'b1;
    else     cmd_q <= cmd_n;
  end

  assign cmd_rise = !cmd_q && cmd_n;
  assign pos_idx  = snap.addr[IDX_W-1:0];
  assign snap_hit = in_window(snap.addr, POS_BASE) && snap.setup;
  assign wr_stb   = cmd_rise && snap_hit && !snap.rd;

  mca_pos_regfile #(
    .ADAPTER_ID (ADAPTER_ID),
    .N_OPT      (4)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .wr_idx   (pos_idx),
    .wr_data  (data_in),
    .rd_idx   (pos_idx),
    .rd_data  (rd_data),
    .opt_bit0 (card_enable)
  );

  assign data_oe    = !cmd_n && snap_hit && snap.rd;
  assign data_out   = data_oe ? rd_data : '0;
  assign snap_tc    = snap.tc;
  assign snap_grant = snap.grant;

endmodule

// File: rtl/mca_pos_responder_chk.sv
module mca_pos_responder_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_n,
  input logic [7:0] data_in,
  input logic [7:0] data_out,
  input logic       data_oe,
  input logic       card_enable,
  input logic       snap_tc,
  input logic       adl_fall,
  input logic       cmd_rise,
  input logic       wr_stb,
  input logic [2:0] pos_idx
);

  // R7: the bus is driven only during the command strobe
  p_oe_in_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> !cmd_n);

  // R2 / R7: an undriven bus carries zero
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> data_out == 8'h00);

  // R3 / R9: captured qualifiers hold between address strobes
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !adl_fall |=> $stable(snap_tc));

  // R5 / R8: the enable changes only through a write strobe
  p_enable_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !cmd_rise |=> $stable(card_enable));

  // R5 / R8: a write to byte 2 lands in the enable bit
  p_enable_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && pos_idx == 3'd2) |=> card_enable == $past(data_in[0]));

  // R4: the hardwired bytes read zero
  p_zero_bytes_r4: assert property (@(posedge clk) disable iff (rst)
    (data_oe && pos_idx[2:1] == 2'b11) |-> data_out == 8'h00);

endmodule

bind mca_pos_responder mca_pos_responder_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_n       (cmd_n),
  .data_in     (data_in),
  .data_out    (data_out),
  .data_oe     (data_oe),
  .card_enable (card_enable),
  .snap_tc     (snap_tc),
  .adl_fall    (adl_fall),
  .cmd_rise    (cmd_rise),
  .wr_stb      (wr_stb),
  .pos_idx     (pos_idx)
);

// File: tb/mca_pos_responder_tb_top.sv
module mca_pos_responder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  // {is_write, addr[15:0], setup, data[7:0], exp_oe, exp_data[7:0]}
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b0, 16'h0100, 1'b1, 8'h00, 1'b1, 8'h91},  // R4 ID low
    {1'b0, 16'h0101, 1'b1, 8'h00, 1'b1, 8'h7E},  // R4 ID high
    {1'b0, 16'h0102, 1'b1, 8'h00, 1'b1, 8'h00},  // R5 reset value
    {1'b1, 16'h0102, 1'b1, 8'h81, 1'b0, 8'h00},
    {1'b0, 16'h0102, 1'b1, 8'h00, 1'b1, 8'h81},  // R5
    {1'b1, 16'h0105, 1'b1, 8'hC4, 1'b0, 8'h00},
    {1'b0, 16'h0105, 1'b1, 8'h00, 1'b1, 8'hC4},  // R5
    {1'b1, 16'h0100, 1'b1, 8'hFF, 1'b0, 8'h00},
    {1'b0, 16'h0100, 1'b1, 8'h00, 1'b1, 8'h91},  // R6
    {1'b1, 16'h0106, 1'b1, 8'h55, 1'b0, 8'h00},
    {1'b0, 16'h0106, 1'b1, 8'h00, 1'b1, 8'h00},  // R6 / R4
    {1'b0, 16'h0107, 1'b1, 8'h00, 1'b1, 8'h00},  // R4
    {1'b0, 16'h0108, 1'b1, 8'h00, 1'b0, 8'h00},  // R1 past window
    {1'b0, 16'h1101, 1'b1, 8'h00, 1'b0, 8'h00},  // R1 upper bits
    {1'b0, 16'h0101, 1'b0, 8'h00, 1'b0, 8'h00},  // R2 not selected
    {1'b1, 16'h0103, 1'b0, 8'h77, 1'b0, 8'h00},
    {1'b0, 16'h0103, 1'b1, 8'h00, 1'b1, 8'h00}   // R2 write dropped
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adl_n = 1'b1, cmd_n = 1'b1, io_read = 1'b0;
  logic [15:0] addr = '0;
  logic       setup_sel = 1'b0, tc_in = 1'b0, grant_in = 1'b0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       data_oe, card_enable, snap_tc, snap_grant;

  int n_checks = 0;
  int n_fail   = 0;
  logic       obs_oe;
  logic [7:0] obs_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  mca_pos_responder dut_i (
    .clk(clk), .rst(rst), .adl_n(adl_n), .cmd_n(cmd_n), .io_read(io_read),
    .addr(addr), .setup_sel(setup_sel), .tc_in(tc_in), .grant_in(grant_in),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .card_enable(card_enable), .snap_tc(snap_tc), .snap_grant(snap_grant)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // One bus cycle; setup_sel may change between strobe and command phase
  task automatic bus_cycle(input logic wr, input logic [15:0] a,
                           input logic s_adl, input logic s_cmd,
                           input logic [7:0] d, input logic tc, input logic gnt);
    @(negedge clk);
    addr = a; io_read = !wr; setup_sel = s_adl; tc_in = tc; grant_in = gnt; adl_n = 1'b0;
    @(negedge clk);
    cmd_n = 1'b0; setup_sel = s_cmd; data_in = d; tc_in = 1'b0; grant_in = 1'b0;
    addr = 16'hFFFF; io_read = wr;
    #1;
    obs_oe = data_oe; obs_data = data_out;
    @(negedge clk);
    cmd_n = 1'b1; adl_n = 1'b1;
    @(negedge clk);
    setup_sel = 1'b0; data_in = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 oe after reset", {7'd0, data_oe}, 8'h00);
    chk("R10 enable after reset", {7'd0, card_enable}, 8'h00);
    cmd_n = 1'b0; #1;
    chk("R10 no drive without strobe", {7'd0, data_oe}, 8'h00);
    @(negedge clk); cmd_n = 1'b1; @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [34:0] v;
      v = VEC[i];
      bus_cycle(v[34], v[33:18], v[17], v[17], v[16:9], 1'b0, 1'b0);
      if (!v[34]) begin
        chk($sformatf("R1/R7 vec %0d oe", i), {7'd0, obs_oe}, {7'd0, v[8]});
        chk($sformatf("R4/R5 vec %0d data", i), obs_data, v[7:0]);
      end else begin
        chk($sformatf("R7 vec %0d write no drive", i), {7'd0, obs_oe}, 8'h00);
      end
    end

    // R8: enable follows byte 2 bit 0
    chk("R8 enable set", {7'd0, card_enable}, 8'h01);
    bus_cycle(1'b1, 16'h0102, 1'b1, 1'b1, 8'h80, 1'b0, 1'b0);
    chk("R8 enable cleared", {7'd0, card_enable}, 8'h00);

    // R3: select dropped after the strobe still answered
    bus_cycle(1'b0, 16'h0101, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    chk("R3 early select oe", {7'd0, obs_oe}, 8'h01);
    chk("R3 early select data", obs_data, 8'h7E);
    // R3: select raised only in the command phase is ignored
    bus_cycle(1'b0, 16'h0100, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
    chk("R3 late select oe", {7'd0, obs_oe}, 8'h00);
    chk("R3 late select data", obs_data, 8'h00);

    // R9: qualifiers captured at the strobe, held afterwards
    bus_cycle(1'b0, 16'h0104, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
    chk("R9 tc held", {7'd0, snap_tc}, 8'h01);
    chk("R9 grant held", {7'd0, snap_grant}, 8'h01);
    bus_cycle(1'b0, 16'h0104, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
    chk("R9 tc recaptured", {7'd0, snap_tc}, 8'h00);

    // R7: oe releases when the command strobe ends
    @(negedge clk);
    addr = 16'h0100; io_read = 1'b1; setup_sel = 1'b1; adl_n = 1'b0;
    @(negedge clk); cmd_n = 1'b0; #1;
    chk("R7 oe in command", {7'd0, data_oe}, 8'h01);
    @(negedge clk); cmd_n = 1'b1; adl_n = 1'b1; #1;
    chk("R7 oe after command", {7'd0, data_oe}, 8'h00);
    chk("R7 data after command", data_out, 8'h00);
    @(negedge clk); setup_sel = 1'b0;

    // R10: reset clears option bytes
    bus_cycle(1'b1, 16'h0102, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0);
    chk("R8 enable before reset", {7'd0, card_enable}, 8'h01);
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk("R10 enable cleared", {7'd0, card_enable}, 8'h00);
    bus_cycle(1'b0, 16'h0102, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
    chk("R10 byte 2 cleared", obs_data, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule